// File: doc/BRIEF.md
# Masked Interrupt Status Unit

This block gathers the five event sources of a serial bus controller into one interrupt line. Each source sets a sticky raw status bit when it pulses. A software-programmed enable register selects which sources may raise the interrupt. Software reads the enabled view of the status, then clears the bits it has handled by writing ones.

The transmit-empty source also has a dedicated one-bit clear word. A transmit refill routine can acknowledge that source alone, without touching the error or completion bits. An error is reported before the completion of the same transfer. Both bits are independent, so the handler sees the error first and the completion later.

Register access uses a simple strobe bus: a write strobe with a word address and write data, and a read strobe whose data is registered. The logic that produces the events lies outside this block.

Top module: `irq_status_unit`

## Requirements
- R1: After reset, the enable mask and raw status are all zero, `irq_o` is low and `rd_data` is zero.
- R2: Source bits are fixed: bit 0 transfer done, bit 1 transfer error, bit 2 FIFO error, bit 3 receive full, bit 4 transmit empty. A one-cycle pulse on `ev_i[b]` sets raw bit b, and the bit stays set until it is cleared.
- R3: A write to word 0 loads the enable mask from `wr_data`, where 1 enables a source and 0 disables it. A read of word 0 returns the mask, zero-extended.
- R4: A read of word 1 returns the raw status ANDed with the mask.
- R5: A read of word 4 returns the raw status whatever the mask holds.
- R6: A write to word 2 clears every raw bit whose `wr_data` bit is 1 and leaves the other raw bits unchanged.
- R7: A write to word 3 with `wr_data[0]`=1 clears raw bit 4 only. With `wr_data[0]`=0 it changes nothing.
- R8: When a source pulses in the same cycle as a clear of its bit, the bit ends up set.
- R9: `irq_o` is registered. It is high one cycle after the masked status becomes nonzero, and low one cycle after it becomes zero.
- R10: Read data is registered on the edge that samples `rd_en` and holds until the next read. Words 2, 3, 5, 6 and 7 read as zero.
- R11: A transfer-error event followed later by a transfer-done event leaves both bits set. Clearing only the error bit keeps the done bit set and `irq_o` high.
- R12: Writes to words 1, 4, 5, 6 and 7 leave the mask and the raw status unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_i | input | NUM_SRC | Event pulses, one per source |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W | Word address for read or write |
| wr_data | input | NUM_SRC | Write data |
| rd_data | output | DATA_W | Registered read data |
| irq_o | output | 1 | Registered interrupt request |

## Verification
Each result has its own latency:
- An event or a clear that is sampled at one edge shows in the raw status at that same edge.
- A read strobed in a cycle delivers its data just after that cycle's edge.
- `irq_o` follows one edge after the status or the mask changes.

The bench drives and samples on falling edges, so every read and every interrupt check lands on the first falling edge at which the value is due. The sweep covers all 32 mask values against all 32 raw patterns. Directed cases cover same-cycle event and clear, the dedicated transmit clear, the error-then-done order, and dead addresses.

// File: rtl/irq_status_unit.sv
module irq_status_unit #(
  parameter int NUM_SRC = 5,
  parameter int TXE_BIT = 4,
  parameter int ADDR_W  = 3,
  parameter int DATA_W  = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] ev_i,
  input  logic               wr_en,
  input  logic               rd_en,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [NUM_SRC-1:0] wr_data,
  output logic [DATA_W-1:0]  rd_data,
  output logic               irq_o
);
  localparam logic [ADDR_W-1:0] A_MASK  = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_MSTAT = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_CLR   = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_TXCLR = ADDR_W'(3);
  localparam logic [ADDR_W-1:0] A_RAW   = ADDR_W'(4);

  logic [NUM_SRC-1:0] mask_q, raw_q, clr_vec, mstat;
  logic [DATA_W-1:0]  rd_mux;

  wire wr_mask  = wr_en && (addr == A_MASK);
  wire wr_clr   = wr_en && (addr == A_CLR);
  wire wr_txclr = wr_en && (addr == A_TXCLR);

  assign mstat = raw_q & mask_q;

  always_comb begin
    clr_vec = wr_clr ? wr_data : '0;
    if (wr_txclr && wr_data[0]) clr_vec[TXE_BIT] = 1'b1;
  end

  always_comb begin
    case (addr)
      A_MASK:  rd_mux = DATA_W'(mask_q);
      A_MSTAT: rd_mux = DATA_W'(mstat);
      A_RAW:   rd_mux = DATA_W'(raw_q);
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q  <= '0;
      raw_q   <= '0;
      irq_o   <= 1'b0;
      rd_data <= '0;
    end else begin
      raw_q <= (raw_q & ~clr_vec) | ev_i;
      if (wr_mask) mask_q <= wr_data;
      irq_o <= |mstat;
      if (rd_en) rd_data <= rd_mux;
    end
  end

  // R2 / R8: a pulsed source is set on the next state, clear or not
  a_r8_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (|ev_i) |=> ((raw_q & $past(ev_i)) == $past(ev_i)));

  // R6: written ones clear bits that are not pulsing
  a_r6_clear_takes: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_CLR) |=> ((raw_q & $past(wr_data & ~ev_i)) == '0));

  // R2: no event and no clear keeps the status
  a_r2_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_i == '0 && !(wr_en && (addr == A_CLR || addr == A_TXCLR))) |=> $stable(raw_q));

  // R3 / R12: mask changes only through its own word
  a_r12_mask_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && addr == A_MASK) |=> $stable(mask_q));

  // R9: interrupt follows the enabled status one cycle later
  a_r9_irq_high: assert property (@(posedge clk) disable iff (!rst_n)
    ((raw_q & mask_q) != '0) |=> irq_o);
  a_r9_irq_low: assert property (@(posedge clk) disable iff (!rst_n)
    ((raw_q & mask_q) == '0) |=> !irq_o);

  // R10: read data holds between reads
  a_r10_rd_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rd_data));
endmodule

// File: tb/irq_status_unit_tb.sv
module irq_status_unit_tb_top;
  localparam int CLK_PERIOD = 10;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [4:0] ev_i = '0, wr_data = '0;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [2:0] addr = '0;
  logic [31:0] rd_data;
  logic irq_o;
  int checks = 0, errors = 0;
  bit done = 0;

  irq_status_unit dut_i (.clk(clk), .rst_n(rst_n), .ev_i(ev_i), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wr_data(wr_data), .rd_data(rd_data), .irq_o(irq_o));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [4:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] v);
    @(negedge clk); rd_en = 1'b1; addr = a;
    @(negedge clk); rd_en = 1'b0; v = rd_data;
  endtask

  task automatic pulse(input logic [4:0] e);
    @(negedge clk); ev_i = e;
    @(negedge clk); ev_i = '0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    #(CLK_PERIOD * 3);
    chk("R1 irq at reset", {31'd0, irq_o}, 0);
    chk("R1 rd_data at reset", rd_data, 0);
    @(negedge clk); rst_n = 1'b1;
    rd(3'd0, v); chk("R1 mask at reset", v, 0);
    rd(3'd4, v); chk("R1 raw at reset", v, 0);

    // R2: each source sets its own bit and stays set
    for (int b = 0; b < 5; b++) begin
      wr(3'd2, 5'h1F);
      pulse(5'(1 << b));
      repeat (3) @(negedge clk);
      rd(3'd4, v); chk("R2 sticky bit", v, 32'(1 << b));
    end

    // R3 R4 R5 R9 sweep of all masks against all raw patterns
    for (int m = 0; m < 32; m++) begin
      wr(3'd0, 5'(m));
      rd(3'd0, v); chk("R3 mask readback", v, 32'(m));
      for (int r = 0; r < 32; r++) begin
        wr(3'd2, 5'h1F);
        pulse(5'(r));
        @(negedge clk);
        chk("R9 irq level", {31'd0, irq_o}, {31'd0, |(5'(r) & 5'(m))});
        rd(3'd1, v); chk("R4 masked status", v, 32'(r & m));
        rd(3'd4, v); chk("R5 raw status", v, 32'(r));
      end
    end

    // R9: irq drops one cycle after the status is cleared
    wr(3'd0, 5'h1F); wr(3'd2, 5'h1F); pulse(5'h01); @(negedge clk);
    chk("R9 irq set", {31'd0, irq_o}, 1);
    @(negedge clk); wr_en = 1'b1; addr = 3'd2; wr_data = 5'h01;
    @(negedge clk); wr_en = 1'b0;
    chk("R9 irq one cycle after clear still high", {31'd0, irq_o}, 1);
    @(negedge clk);
    chk("R9 irq low after clear", {31'd0, irq_o}, 0);

    // R6: partial clear
    pulse(5'h1F); wr(3'd2, 5'h0A);
    rd(3'd4, v); chk("R6 partial clear", v, 32'h15);
    wr(3'd2, 5'h00);
    rd(3'd4, v); chk("R6 zero clear no effect", v, 32'h15);

    // R7: dedicated transmit-empty clear
    pulse(5'h1F); wr(3'd3, 5'h1F);
    rd(3'd4, v); chk("R7 tx clear only bit4", v, 32'h0F);
    pulse(5'h10); wr(3'd3, 5'h1E);
    rd(3'd4, v); chk("R7 tx clear bit0 zero", v, 32'h1F);

    // R8: event and clear in one cycle
    wr(3'd2, 5'h1F);
    @(negedge clk); ev_i = 5'h04; wr_en = 1'b1; addr = 3'd2; wr_data = 5'h1F;
    @(negedge clk); ev_i = '0; wr_en = 1'b0;
    rd(3'd4, v); chk("R8 event wins", v, 32'h04);
    @(negedge clk); ev_i = 5'h10; wr_en = 1'b1; addr = 3'd3; wr_data = 5'h01;
    @(negedge clk); ev_i = '0; wr_en = 1'b0;
    rd(3'd4, v); chk("R8 event wins tx clear", v, 32'h14);

    // R11: error first, done later
    wr(3'd2, 5'h1F); wr(3'd0, 5'h03);
    pulse(5'h02);
    rd(3'd1, v); chk("R11 error first", v, 32'h02);
    repeat (4) @(negedge clk);
    pulse(5'h01);
    rd(3'd1, v); chk("R11 both set", v, 32'h03);
    wr(3'd2, 5'h02); @(negedge clk);
    rd(3'd1, v); chk("R11 done remains", v, 32'h01);
    chk("R11 irq still high", {31'd0, irq_o}, 1);

    // R10: write-only and dead words read zero, data holds
    for (int a = 2; a < 8; a++) begin
      if (a == 4) continue;
      rd(3'(a), v); chk("R10 read zero word", v, 0);
    end
    rd(3'd0, v);
    repeat (3) @(negedge clk);
    chk("R10 data holds", rd_data, 32'h03);

    // R12: writes to status and dead words have no effect
    wr(3'd2, 5'h1F); pulse(5'h05);
    for (int a = 4; a < 8; a++) wr(3'(a), 5'h1F);
    wr(3'd1, 5'h1F);
    rd(3'd0, v); chk("R12 mask unchanged", v, 32'h03);
    rd(3'd4, v); chk("R12 raw unchanged", v, 32'h05);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule